// File: doc/BRIEF.md
# Serial Weighted-Sum Calibration Engine

This block forms the calibrated output of a successive-approximation converter. Each raw decision bit has its own stored signed digital weight. The calibrated value is the sum of the weights whose bits are 1. The block does not multiply every bit by its weight at the same time. Instead, a short step counter follows the converter's bit-cycle strobes. For each step it selects one weight and adds it into a single shared accumulator when that step's bit is 1.

The sampling strobe closes one conversion and opens the next. On that strobe the finished sum moves to the output register, a one-cycle valid pulse is raised, and the accumulator and step counter return to zero. Weights come from an offline fit and are loaded through a plain address/data/write-enable port. A weight bank holds pending writes and switches to them only at a sampling strobe, so a conversion that is in progress always uses one consistent weight set. All strobes are single-cycle pulses that are synchronous to `clk`.

Top module: `cal_wsum_engine`

## Requirements
- R1: Raw bits arrive MSB first, one per `bit_stb` pulse. At step k (k = 0 for the first bit after a sampling strobe) the engine uses the weight stored at address NBITS-1-k. At the end of the conversion, `out_word` equals the sum over all bits i of bit_i times the weight at address i.
- R2: Weights are WW-bit two's-complement values, sign-extended into an accumulator of WW+CW bits. NBITS terms at either extreme (all -2^(WW-1) or all 2^(WW-1)-1) are summed without overflow.
- R3: On a cycle with `smp_stb` high, the accumulated value is captured into `out_word`, and `out_vld` is high for exactly the following cycle. After reset, `out_vld` is 0 and `out_word` is 0.
- R4: `smp_stb` clears the accumulator and the step counter, so the next conversion starts at step 0. A `bit_stb` in the same cycle as `smp_stb` is discarded.
- R5: The step counter stops at NBITS. Bit strobes beyond the NBITS-th in one conversion add nothing.
- R6: A step whose bit is 0 adds nothing to the sum.
- R7: A weight write made during a conversion first applies to the conversion that begins at the next `smp_stb`. A write in the same cycle as `smp_stb` applies to the conversion that strobe begins.
- R8: `out_word` holds its value on every cycle without `smp_stb`.
- R9: `bit_val` has no effect while `bit_stb` is low.
- R10: Writes to addresses NBITS and above are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sampling strobe: ends one conversion and starts the next |
| bit_stb | input | 1 | Bit-cycle strobe, one per resolved raw bit |
| bit_val | input | 1 | Raw bit decision for the current bit strobe |
| wr_en | input | 1 | Weight write enable |
| wr_addr | input | CW | Weight address (raw bit index) |
| wr_data | input | WW | Signed weight value |
| out_vld | output | 1 | One-cycle pulse after each sampling strobe |
| out_word | output | WW+CW | Calibrated signed output |

## Verification
The bound checker watches the following on every cycle:
- the step counter stays within its limit;
- the valid pulse follows each sampling strobe and appears at no other time;
- the captured word matches the accumulator before the strobe;
- the accumulator and step counter clear on a restart;
- the accumulator does not change on idle cycles, zero bits, or saturated strobes;
- the output word holds between strobes.

Checks that need known weights can only come from the bench scenarios:
- correctness of the sum itself, including bit-to-weight ordering and sign extension at both extremes;
- the exact conversion at which a pending weight write takes effect;
- rejection of writes to unused addresses.

The bench sweeps every raw code of a six-bit configuration under several weight sets.

// File: rtl/cal_wsum_pkg.sv
package cal_wsum_pkg;

  // Weight address used at a given step; bits arrive MSB first.
  function automatic int weight_index(int step, int nbits);
    if (step < nbits) return nbits - 1 - step;
    else return 0;
  endfunction

  // Accumulator width needed for up to 2**cw signed terms of ww bits.
  function automatic int acc_width(int ww, int cw);
    return ww + cw;
  endfunction

endpackage

// File: rtl/cal_stepper.sv
module cal_stepper #(
  parameter int NBITS = 15,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [CW-1:0] step_cnt,
  output logic          step_full
);
  localparam logic [CW-1:0] LIMIT = CW'(NBITS);

  assign step_full = (step_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     step_cnt <= '0;
    else if (restart)               step_cnt <= '0;
    else if (advance && !step_full) step_cnt <= step_cnt + 1'b1;
  end
endmodule

// File: rtl/cal_wbank.sv
module cal_wbank #(
  parameter int NBITS = 15,
  parameter int WW    = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          load,
  input  logic [CW-1:0] sel_step,
  output logic [WW-1:0] w_sel
);
  logic [WW-1:0] shadow     [NBITS];
  logic [WW-1:0] shadow_nxt [NBITS];
  logic [WW-1:0] active     [NBITS];

  for (genvar g = 0; g < NBITS; g++) begin : g_entry
    localparam logic [CW-1:0] ADDR = CW'(g);

    assign shadow_nxt[g] = (wr_en && (wr_addr == ADDR)) ? wr_data : shadow[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[g] <= '0;
        active[g] <= '0;
      end else begin
        shadow[g] <= shadow_nxt[g];
        if (load) active[g] <= shadow_nxt[g];
      end
    end
  end

  int sel_idx;
  assign sel_idx = cal_wsum_pkg::weight_index(int'(sel_step), NBITS);

  always_comb begin
    w_sel = '0;
    for (int i = 0; i < NBITS; i++) begin
      if (i == sel_idx) w_sel = active[i];
    end
  end
endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
  parameter int WW   = 16,
  parameter int ACCW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            term_en,
  input  logic            bit_val,
  input  logic [WW-1:0]   w_sel,
  output logic [ACCW-1:0] acc,
  output logic [ACCW-1:0] out_word,
  output logic            out_vld
);
  function automatic logic [ACCW-1:0] sext(input logic [WW-1:0] w);
    return {{(ACCW-WW){w[WW-1]}}, w};
  endfunction

  function automatic logic [ACCW-1:0] add_term(input logic [ACCW-1:0] a,
                                               input logic [WW-1:0]   w,
                                               input logic            take);
    return take ? a + sext(w) : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      out_word <= '0;
      out_vld  <= 1'b0;
    end else if (clear) begin
      out_word <= acc;
      out_vld  <= 1'b1;
      acc      <= '0;
    end else begin
      out_vld  <= 1'b0;
      acc      <= add_term(acc, w_sel, term_en && bit_val);
    end
  end
endmodule

// File: rtl/cal_wsum_engine.sv
module cal_wsum_engine #(
  parameter int NBITS = 15,
  parameter int WW    = 16,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_addr,
  input  logic [WW-1:0]    wr_data,
  output logic             out_vld,
  output logic [WW+CW-1:0] out_word
);
  localparam int ACCW = cal_wsum_pkg::acc_width(WW, CW);

  logic [CW-1:0]   step_cnt;
  logic            step_full;
  logic            term_en;
  logic [WW-1:0]   w_sel;
  logic [ACCW-1:0] acc;

  // a bit term is taken only outside a restart and below the step limit
  assign term_en = bit_stb && !smp_stb && !step_full;

  cal_stepper #(.NBITS(NBITS), .CW(CW)) u_step (
    .clk(clk), .rst_n(rst_n), .restart(smp_stb), .advance(bit_stb),
    .step_cnt(step_cnt), .step_full(step_full)
  );

  cal_wbank #(.NBITS(NBITS), .WW(WW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(smp_stb), .sel_step(step_cnt), .w_sel(w_sel)
  );

  cal_accum #(.WW(WW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(smp_stb), .term_en(term_en),
    .bit_val(bit_val), .w_sel(w_sel), .acc(acc),
    .out_word(out_word), .out_vld(out_vld)
  );
endmodule

// File: rtl/cal_wsum_chk.sv
module cal_wsum_chk #(
  parameter int NBITS = 15,
  parameter int CW    = 4,
  parameter int ACCW  = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_stb,
  input logic            bit_stb,
  input logic            bit_val,
  input logic            out_vld,
  input logic [ACCW-1:0] out_word,
  input logic [ACCW-1:0] acc,
  input logic [CW-1:0]   step_cnt,
  input logic            step_full
);
  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_cnt) <= NBITS);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !smp_stb && step_full) |=> ($stable(acc) && $stable(step_cnt)));

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);

  // R3
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);

  // R3
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (out_word == $past(acc)));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (step_cnt == '0 && acc == '0));

  // R6
  zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !bit_val && !smp_stb) |=> $stable(acc));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !smp_stb) |=> ($stable(acc) && $stable(step_cnt)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(out_word));
endmodule

bind cal_wsum_engine cal_wsum_chk #(.NBITS(NBITS), .CW(CW), .ACCW(WW+CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_stb(bit_stb),
  .bit_val(bit_val), .out_vld(out_vld), .out_word(out_word), .acc(acc),
  .step_cnt(step_cnt), .step_full(step_full)
);

// File: tb/sim_cal_wsum_engine.sv
module sim_cal_wsum_engine;
  localparam int NB   = 6;
  localparam int WW   = 16;
  localparam int CW   = 3;
  localparam int ACCW = WW + CW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            smp_stb = 1'b0, bit_stb = 1'b0, bit_val = 1'b0, wr_en = 1'b0;
  logic [CW-1:0]   wr_addr = '0;
  logic [WW-1:0]   wr_data = '0;
  logic            out_vld;
  logic [ACCW-1:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int wm [NB];

  always #5 clk = ~clk;

  cal_wsum_engine #(.NBITS(NB), .WW(WW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_stb(bit_stb),
    .bit_val(bit_val), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_vld(out_vld), .out_word(out_word)
  );

  function automatic int expect_sum(int code);
    int s = 0;
    for (int i = 0; i < NB; i++) if (code[i]) s += wm[i];
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_all();
    smp_stb = 0; bit_stb = 0; bit_val = 0; wr_en = 0;
  endtask

  task automatic send_bit(bit b);
    bit_stb = 1; bit_val = b;
    @(negedge clk);
    idle_all();
  endtask

  task automatic write_w(int a, int d);
    wr_en = 1; wr_addr = CW'(a); wr_data = WW'(d); bit_val = 1;
    @(negedge clk);
    idle_all();
  endtask

  // sampling strobe, optionally with a same-cycle write; returns captured word
  task automatic smp(output int word, output bit vld, input bit wr = 0,
                     input int a = 0, input int d = 0);
    smp_stb = 1;
    if (wr) begin wr_en = 1; wr_addr = CW'(a); wr_data = WW'(d); end
    @(negedge clk);
    idle_all();
    word = int'($signed(out_word));
    vld = out_vld;
  endtask

  task automatic conv(int code, int extra, string req);
    int w; bit v;
    for (int k = 0; k < NB; k++) send_bit(code[NB-1-k]);
    for (int k = 0; k < extra; k++) send_bit(1'b1);
    smp(w, v);
    check(req, w, expect_sum(code));
  endtask

  task automatic load_set(int sel);
    int w; bit v;
    for (int i = 0; i < NB; i++) begin
      case (sel)
        0: wm[i] = 1200 * (i + 1) - ((i % 2) ? 5000 : 0);
        1: wm[i] = -9000 + 3100 * i;
        2: wm[i] = 32767;
        default: wm[i] = -32768;
      endcase
      write_w(i, wm[i]);
    end
    smp(w, v);  // prime: the new set applies from here on
  endtask

  initial begin
    int w; bit v;
    @(negedge clk);
    // R3 reset state
    check("R3 reset vld", int'(out_vld), 0);
    check("R3 reset word", int'(out_word), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 R6 exhaustive sweep under two weight sets
    for (int s = 0; s < 2; s++) begin
      load_set(s);
      for (int c = 0; c < (1 << NB); c++) conv(c, 0, "R1/R6 sweep");
    end

    // R3 valid pulse lasts exactly one cycle
    for (int k = 0; k < NB; k++) send_bit(1'b1);
    smp(w, v);
    check("R3 vld high", int'(v), 1);
    @(negedge clk);
    check("R3 vld drop", int'(out_vld), 0);
    // R8 word holds between strobes
    check("R8 hold", int'($signed(out_word)), expect_sum(63));
    send_bit(1'b1);
    check("R8 hold during bits", int'($signed(out_word)), expect_sum(63));
    smp(w, v);

    // R2 extremes
    load_set(2);
    conv(63, 0, "R2 max positive");
    load_set(3);
    conv(63, 0, "R2 max negative");
    conv(32, 0, "R2 single negative");

    // R5 saturation: extra strobes add nothing
    load_set(0);
    conv(63, 3, "R5 extra strobes");
    conv(21, 5, "R5 extra strobes alt");

    // R9 bit_val toggling without strobe
    for (int k = 0; k < NB; k++) begin
      bit_val = 1; @(negedge clk);
      send_bit((k % 2) == 0);
    end
    smp(w, v);
    check("R9 bit_val ignored", w, expect_sum(42));

    // R4 coincident bit strobe discarded, restart at step 0
    send_bit(1'b1); send_bit(1'b1);
    bit_stb = 1; bit_val = 1;
    smp(w, v);
    check("R4 coincident strobe", w, wm[5] + wm[4]);
    conv(63, 0, "R4 restart step 0");

    // R7 write mid-conversion applies next conversion
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    write_w(5, 777);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    smp(w, v);
    check("R7 old weight in use", w, expect_sum(63));
    wm[5] = 777;
    conv(63, 0, "R7 new weight applied");

    // R7 write in the same cycle as the strobe
    for (int k = 0; k < NB; k++) send_bit(1'b1);
    smp(w, v, 1'b1, 0, -4321);
    check("R7 strobe-cycle old", w, expect_sum(63));
    wm[0] = -4321;
    conv(1, 0, "R7 strobe-cycle new");

    // R10 out-of-range addresses ignored
    write_w(6, 12345);
    write_w(7, -2222);
    smp(w, v);
    conv(63, 0, "R10 ignored write");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule